// File: doc/BRIEF.md
# Test-Pin Wait Synchronizer

This block holds a processor core idle while a wait-type instruction waits for an external, active-low test pin. The core raises `wait_req` for one cycle. The block then stalls the core until the pin has been seen low on enough consecutive cycles. Each stalled cycle re-evaluates the wait condition, and no bus traffic is issued while the core is stalled. When the wait ends normally, the block gives a one-cycle `done` pulse.

An enabled, pending interrupt can end the stall early. In that case the block pulses `take_irq` together with `bus_req`. That bus request stands for the one extra fetch of the wait instruction. The block then waits for the core to report that the interrupt handler has returned. At that point it pulses `refetch_wait` with `bus_req`, so the core fetches the wait instruction again and runs it again. The pin goes through a configurable flop synchronizer before it is counted. The length of the qualification run is a parameter, with a default of 5 cycles.

Top module: `test_wait_sync`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, all outputs (`stall`, `done`, `take_irq`, `refetch_wait`, `bus_req`) are 0.
- R2: A `wait_req` sampled high while idle raises `stall` from the next cycle. If the synchronized pin reads high (1 = inactive), `stall` stays high and `done` stays low.
- R3: `test_n` passes through two flops before it is counted. A low first sampled at rising edge e0, with the core already stalled, does not produce `done` before the cycle after edge e6.
- R4: With the stall active and `test_n` held low from edge e0 on, `done` is 1 in the cycle after edge e6.
- R5: A low run shorter than 5 synchronized samples, followed by a high, clears the count. The stall continues and no `done` appears.
- R6: While stalled and not qualified, the condition is re-checked every cycle. `stall` stays high for as long as the pin stays high.
- R7: `bus_req` is 0 in every cycle in which `stall` is 1. It is 1 only together with `take_irq` or `refetch_wait`.
- R8: When `irq_pending` and `irq_enable` are both sampled high during a stall cycle, the next cycle has `stall`=0, `take_irq`=1 and `bus_req`=1, each for exactly one cycle.
- R9: While `irq_enable` is 0, `irq_pending` has no effect. The stall continues and `take_irq` stays 0.
- R10: After `take_irq`, `refetch_wait` stays 0 until `irq_return` is sampled high. In the following cycle, `refetch_wait`=1 and `bus_req`=1 for one cycle.
- R11: `done` is a one-cycle pulse, and `stall` is 0 in the cycle in which `done` is 1.
- R12: If the synchronized pin is already low when the request arrives, counting starts in the first stall cycle. The stall then lasts exactly 5 cycles.
- R13: If qualification completes in the same cycle in which an enabled interrupt is pending, completion wins: `done`=1 and `take_irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wait_req | input | 1 | Core starts a wait instruction (one-cycle strobe) |
| test_n | input | 1 | External test pin, active low, asynchronous |
| irq_pending | input | 1 | An interrupt is pending at the core |
| irq_enable | input | 1 | Interrupts are enabled |
| irq_return | input | 1 | The interrupt handler has returned |
| stall | output | 1 | Hold the core idle |
| done | output | 1 | Wait completed (one-cycle pulse) |
| take_irq | output | 1 | Leave the wait to service the interrupt |
| refetch_wait | output | 1 | Fetch and execute the wait instruction again |
| bus_req | output | 1 | Instruction fetch bus request |

## Verification
The hardest case to reach from the ports is a qualification that completes in the very cycle an enabled interrupt becomes pending. Without exact cycle alignment, that priority rule is never exercised. The bench reaches it by first letting the synchronizer settle with the pin low. It then counts stall cycles after the request and raises the interrupt lines during the fifth one. The three-edge latency from the pin to the count is measured the same way: the pin is lowered while the stall is active, and `done` is sampled on each side of the computed edge.

// File: rtl/twsync_pkg.sv
package twsync_pkg;

  typedef enum logic [2:0] {
    TW_IDLE,
    TW_WAIT,
    TW_FIN,
    TW_IRQ,
    TW_SVC,
    TW_REFETCH
  } tw_state_e;

  // next value of the consecutive-low counter, saturating at lim
  function automatic int unsigned qual_next(int unsigned cnt, logic low, int unsigned lim);
    if (!low) return 0;
    if (cnt >= lim) return lim;
    return cnt + 1;
  endfunction

  // true when this low sample is the lim-th consecutive one
  function automatic logic qual_reached(int unsigned cnt, logic low, int unsigned lim);
    return low && ((cnt + 1) >= lim);
  endfunction

endpackage

// File: rtl/twsync_sync.sv
module twsync_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES <= 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= d;
      end
      assign q = r_q;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/twsync_qual.sv
module twsync_qual
  import twsync_pkg::*;
#(
  parameter int unsigned QUAL  = 5,
  parameter int unsigned CNT_W = $clog2(QUAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             low,
  output logic             hit,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!sample_en) cnt_d = '0;
    else            cnt_d = CNT_W'(qual_next(32'(cnt_q), low, QUAL));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hit = sample_en && qual_reached(32'(cnt_q), low, QUAL);
  assign cnt = cnt_q;

endmodule

// File: rtl/twsync_ctrl.sv
module twsync_ctrl
  import twsync_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic qual_hit,
  input  logic irq_go,
  input  logic irq_return,
  output logic in_wait,
  output logic stall,
  output logic done,
  output logic take_irq,
  output logic refetch_wait,
  output logic bus_req
);

  tw_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      TW_IDLE:    if (wait_req) st_d = TW_WAIT;
      TW_WAIT: begin
        if (qual_hit)    st_d = TW_FIN;   // completion has priority
        else if (irq_go) st_d = TW_IRQ;
      end
      TW_FIN:     st_d = TW_IDLE;
      TW_IRQ:     st_d = TW_SVC;
      TW_SVC:     if (irq_return) st_d = TW_REFETCH;
      TW_REFETCH: st_d = TW_IDLE;
      default:    st_d = TW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= TW_IDLE;
    else        st_q <= st_d;
  end

  assign in_wait      = (st_q == TW_WAIT);
  assign stall        = in_wait;
  assign done         = (st_q == TW_FIN);
  assign take_irq     = (st_q == TW_IRQ);
  assign refetch_wait = (st_q == TW_REFETCH);
  assign bus_req      = take_irq || refetch_wait;

endmodule

// File: rtl/test_wait_sync.sv
module test_wait_sync #(
  parameter int unsigned QUAL_CYCLES = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_req,
  input  logic test_n,
  input  logic irq_pending,
  input  logic irq_enable,
  input  logic irq_return,
  output logic stall,
  output logic done,
  output logic take_irq,
  output logic refetch_wait,
  output logic bus_req
);

  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);

  logic             test_s;
  logic             test_low;
  logic             in_wait;
  logic             qual_hit;
  logic             irq_go;
  logic [CNT_W-1:0] qual_cnt;

  twsync_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (test_n),
    .q     (test_s)
  );

  assign test_low = !test_s;
  assign irq_go   = irq_pending && irq_enable;

  twsync_qual #(.QUAL(QUAL_CYCLES), .CNT_W(CNT_W)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (in_wait),
    .low       (test_low),
    .hit       (qual_hit),
    .cnt       (qual_cnt)
  );

  twsync_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .wait_req     (wait_req),
    .qual_hit     (qual_hit),
    .irq_go       (irq_go),
    .irq_return   (irq_return),
    .in_wait      (in_wait),
    .stall        (stall),
    .done         (done),
    .take_irq     (take_irq),
    .refetch_wait (refetch_wait),
    .bus_req      (bus_req)
  );

endmodule

// File: rtl/twsync_checker.sv
module twsync_checker #(
  parameter int unsigned CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_pending,
  input logic             irq_enable,
  input logic             irq_return,
  input logic             test_s,
  input logic             qual_hit,
  input logic [CNT_W-1:0] qual_cnt,
  input logic             stall,
  input logic             done,
  input logic             take_irq,
  input logic             refetch_wait,
  input logic             bus_req
);

  assert_no_bus_in_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !bus_req);

  assert_done_no_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !stall);

  assert_done_one_cycle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall && qual_hit |=> done && $past(!test_s));

  assert_high_blocks_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall && test_s |=> !done);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(take_irq) |-> $past(stall && irq_pending && irq_enable));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !irq_enable |=> !take_irq);

  assert_refetch_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refetch_wait |-> $past(irq_return));

  assert_completion_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
    stall && qual_hit && irq_pending && irq_enable |=> !take_irq);

  assert_count_zero_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (qual_cnt == '0) || stall);

endmodule

bind test_wait_sync twsync_checker #(.CNT_W(CNT_W)) u_twsync_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq_pending  (irq_pending),
  .irq_enable   (irq_enable),
  .irq_return   (irq_return),
  .test_s       (test_s),
  .qual_hit     (qual_hit),
  .qual_cnt     (qual_cnt),
  .stall        (stall),
  .done         (done),
  .take_irq     (take_irq),
  .refetch_wait (refetch_wait),
  .bus_req      (bus_req)
);

// File: tb/test_wait_sync_bench.sv
`timescale 1ns/1ps
module test_wait_sync_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wait_req = 1'b0, test_n = 1'b1;
  logic irq_pending = 1'b0, irq_enable = 1'b0, irq_return = 1'b0;
  logic stall, done, take_irq, refetch_wait, bus_req;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;   // 50 MHz

  test_wait_sync u_test_wait_sync (
    .clk(clk), .rst_n(rst_n), .wait_req(wait_req), .test_n(test_n),
    .irq_pending(irq_pending), .irq_enable(irq_enable), .irq_return(irq_return),
    .stall(stall), .done(done), .take_irq(take_irq),
    .refetch_wait(refetch_wait), .bus_req(bus_req)
  );

  // ---------------- behavioural reference ----------------
  // phase: 0 idle, 1 waiting, 2 finished, 3 leave-for-irq, 4 in handler, 5 refetch
  int   phase = 0;
  int   low_run = 0;
  logic pin_q[$] = '{1'b1, 1'b1};  // pin history, oldest first
  logic seen_pin;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; low_run = 0; pin_q = '{1'b1, 1'b1};
    end else begin
      seen_pin = pin_q[0];
      case (phase)
        0: if (wait_req) begin phase = 1; low_run = 0; end
        1: begin
          low_run = seen_pin ? 0 : low_run + 1;
          if (low_run >= 5) phase = 2;
          else if (irq_pending && irq_enable) phase = 3;
        end
        2: phase = 0;
        3: phase = 4;
        4: if (irq_return) phase = 5;
        default: phase = 0;
      endcase
      if (phase != 1) low_run = 0;
      void'(pin_q.pop_front());
      pin_q.push_back(test_n);
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare the design with the reference every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 stall (model)",        stall,        phase == 1);
      chk("R11 done (model)",        done,         phase == 2);
      chk("R8 take_irq (model)",     take_irq,     phase == 3);
      chk("R10 refetch_wait (model)", refetch_wait, phase == 5);
      chk("R7 bus_req (model)",      bus_req,      phase == 3 || phase == 5);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req();
    wait_req = 1'b1;
    cyc(1);
    wait_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int n;
    logic bad;
    cyc(2);
    chk("R1 stall in reset", stall, 1'b0);
    chk("R1 bus_req in reset", bus_req, 1'b0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 done after reset", done, 1'b0);
    chk("R1 take_irq after reset", take_irq, 1'b0);
    chk("R1 refetch_wait after reset", refetch_wait, 1'b0);

    // R12: pin already low at request -> exactly 5 stall cycles
    test_n = 1'b0; cyc(3);
    pulse_req();
    n = 0;
    for (int i = 0; i < 40 && !done; i++) begin
      if (stall) n++;
      cyc(1);
    end
    chk("R12 stall length is 5", n == 5, 1'b1);
    chk("R11 stall low with done", stall, 1'b0);
    cyc(1);
    chk("R11 done is one cycle", done, 1'b0);

    // R2/R6: pin high -> stall holds indefinitely
    test_n = 1'b1; cyc(3);
    pulse_req();
    chk("R2 stall raised", stall, 1'b1);
    bad = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!stall || done) bad = 1'b1;
      cyc(1);
    end
    chk("R6 stall held while pin high", bad, 1'b0);

    // R5: a 4-cycle low pulse does not release
    test_n = 1'b0; cyc(4); test_n = 1'b1;
    bad = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!stall || done) bad = 1'b1;
      cyc(1);
    end
    chk("R5 short low ignored", bad, 1'b0);

    // R3/R4: latency from pin to done
    test_n = 1'b0;
    cyc(6);
    chk("R3 no done before seventh edge", done, 1'b0);
    chk("R3 still stalled", stall, 1'b1);
    cyc(1);
    chk("R4 done after seventh edge", done, 1'b1);

    // R9/R8/R10: interrupt interplay
    test_n = 1'b1; cyc(3);
    pulse_req();
    irq_pending = 1'b1; irq_enable = 1'b0;
    bad = 1'b0;
    for (int i = 0; i < 10; i++) begin
      cyc(1);
      if (!stall || take_irq) bad = 1'b1;
    end
    chk("R9 masked interrupt ignored", bad, 1'b0);
    irq_enable = 1'b1;
    cyc(1);
    chk("R8 take_irq", take_irq, 1'b1);
    chk("R8 stall released", stall, 1'b0);
    chk("R8 extra fetch bus_req", bus_req, 1'b1);
    irq_pending = 1'b0; irq_enable = 1'b0;
    cyc(1);
    chk("R8 take_irq one cycle", take_irq, 1'b0);
    bad = 1'b0;
    for (int i = 0; i < 5; i++) begin
      if (refetch_wait || bus_req) bad = 1'b1;
      cyc(1);
    end
    chk("R10 no refetch before return", bad, 1'b0);
    irq_return = 1'b1;
    cyc(1);
    irq_return = 1'b0;
    chk("R10 refetch_wait", refetch_wait, 1'b1);
    chk("R7 bus_req with refetch", bus_req, 1'b1);
    cyc(1);
    chk("R10 refetch one cycle", refetch_wait, 1'b0);

    // R13: completion and interrupt in the same cycle
    test_n = 1'b0; cyc(3);
    pulse_req();
    cyc(4);
    irq_pending = 1'b1; irq_enable = 1'b1;
    cyc(1);
    chk("R13 done wins", done, 1'b1);
    chk("R13 no take_irq", take_irq, 1'b0);
    irq_pending = 1'b0; irq_enable = 1'b0;
    cyc(2);

    // mixed traffic, checked against the reference each cycle
    for (int i = 0; i < 4000; i++) begin
      wait_req    = ($urandom % 6) == 0;
      if (($urandom % 9) == 0) test_n = ~test_n;
      irq_pending = ($urandom % 10) == 0;
      irq_enable  = ($urandom % 2) == 0;
      irq_return  = ($urandom % 7) == 0;
      cyc(1);
    end
    wait_req = 1'b0; irq_pending = 1'b0; irq_return = 1'b0;
    cyc(2);
    finish_run();
  end

endmodule